// File: doc/BRIEF.md
# PLL Power-Up Sequencing Controller

This block drives the three digital controls of an analog PLL (bypass release, reset release, output enable) in a safe order. Software reaches it through a small word-addressed register port. A one-cycle pulse on `tick_i` once per microsecond is the timebase, and `lock_i` reports lock from the PLL. An enable command releases bypass, waits a fixed spacing, releases reset, then polls lock once per tick for a bounded number of tries. The output is turned on only when lock is seen. A disable command drops all three controls in the same cycle.

Divider values (L, M, N) are written to staging registers and copied to the PLL by a rate-apply command. If the PLL is fully running when that command arrives, the block takes it down, loads the new dividers and runs the whole enable sequence again. A hardware voting mode can be armed. While it is armed, a voting state machine owns the three controls, driven by `vote_req_i` and the programmed bias and lock counts. The software enable, disable and rate commands then have no effect.

Register map (word address on `reg_addr_i`):
- 0 MODE: bit 0 output-on, bit 1 bypass released and bit 2 reset released (all read-only); lock count [13:8]; bias count [19:14]; vote enable [20]; vote FSM reset [21].
- 1 CMD (write-only, reads 0): bit 0 enable, bit 1 disable, bit 2 rate apply.
- 2 L, 3 M, 4 N: staged dividers, right-aligned.
- 5 STAT: bit 0 busy (read-only), bit 1 timeout (sticky, write 1 to clear).

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset all three controls, the dividers, busy, timeout, both counts and vote enable are 0, and vote FSM reset is 1, so MODE reads 0x0020_0000.
- R2: The cycle after an accepted enable, only bypass release is set. Reset release follows on the 10th tick after that. Output enable is set at the first later tick where `lock_i` is high. Output-on always implies reset released, and reset released always implies bypass released.
- R3: An enable is ignored while all three controls are set, while busy, or while vote mode is armed. An enable from a partial state restarts the sequence with only bypass release set.
- R4: If 200 ticks of polling pass without lock, the timeout flag sets, busy clears, output stays off, and bypass and reset releases stay set.
- R5: A disable clears all three controls the next cycle and aborts any running sequence. A disable wins over an enable or a lock tick in the same cycle. In vote mode a disable has no effect.
- R6: Timeout (STAT bit 1) is cleared only by writing 1 to it. Writing 0 leaves it set.
- R7: Busy (STAT bit 0, `busy_o`) is high for the whole of a sequence. Writes to L, M or N while busy are dropped, and the divider outputs hold steady.
- R8: Rate apply copies L, M and N to the outputs. If the PLL was fully running, all controls clear the next cycle and a full enable sequence follows. Otherwise no sequence runs. Rate apply wins over enable in the same write.
- R9: Vote enable can be set only if vote FSM reset was already 0 and is written 0 in the same write. Writing vote FSM reset to 1 clears vote enable.
- R10: In vote mode with `vote_req_i` high, bypass is released first. Reset is released once bias-count ticks have elapsed. Output-on follows once lock-count ticks have elapsed and `lock_i` is high. Dropping `vote_req_i` clears all three controls the next cycle. Arming vote mode clears the software sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| tick_i | input | 1 | One-cycle pulse per microsecond |
| lock_i | input | 1 | PLL lock status |
| vote_req_i | input | 1 | Hardware vote request |
| byp_rel_o | output | 1 | Bypass released |
| rst_rel_o | output | 1 | PLL reset released |
| out_en_o | output | 1 | PLL output enabled |
| l_o | output | L_W | Active L divider |
| m_o | output | M_W | Active M divider |
| n_o | output | N_W | Active N divider |
| busy_o | output | 1 | Sequence in progress |
| timeout_o | output | 1 | Sticky lock-timeout flag |

## Verification
The sharpest collision is a disable command written in the very cycle where a tick finds `lock_i` high during polling. In that cycle the sequencer would otherwise turn the output on. The bench stops the free-running tick and issues ticks by hand until reset release is seen. It then drives the deciding tick, lock and the disable write together, and requires all three controls to read 0 the next cycle with output-on never set. A cycle-by-cycle behavioural model also judges enable and disable written in one word, and the timeout setting against a clear write.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef struct packed {
    logic rst_rel;
    logic byp_rel;
    logic out_en;
  } pll_ctl_t;

  typedef enum logic [1:0] {SW_IDLE, SW_GAP, SW_POLL, SW_RESTART} sw_state_e;
  typedef enum logic [1:0] {VT_IDLE, VT_BIAS, VT_LOCK, VT_ON} vt_state_e;

  localparam int AW      = 3;
  localparam int DW      = 32;
  localparam int VCNT_W  = 6;

  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_CMD  = 3'd1;
  localparam logic [AW-1:0] A_L    = 3'd2;
  localparam logic [AW-1:0] A_M    = 3'd3;
  localparam logic [AW-1:0] A_N    = 3'd4;
  localparam logic [AW-1:0] A_STAT = 3'd5;

  localparam int LOCK_LSB = 8;
  localparam int BIAS_LSB = 14;
  localparam int VEN_BIT  = 20;
  localparam int VRST_BIT = 21;

  localparam int CMD_EN   = 0;
  localparam int CMD_DIS  = 1;
  localparam int CMD_RATE = 2;

  localparam int ST_BUSY  = 0;
  localparam int ST_TOUT  = 1;
endpackage

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
  import pll_seq_pkg::*;
#(
  parameter int L_W = 10,
  parameter int M_W = 19,
  parameter int N_W = 19
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            busy_i,
  input  pll_ctl_t        ctl_i,
  input  logic            tout_set_i,
  output logic            cmd_en_o,
  output logic            cmd_dis_o,
  output logic            cmd_rate_o,
  output logic [VCNT_W-1:0] lock_cnt_o,
  output logic [VCNT_W-1:0] bias_cnt_o,
  output logic            vote_en_o,
  output logic            vote_rst_o,
  output logic [L_W-1:0]  l_stg_o,
  output logic [M_W-1:0]  m_stg_o,
  output logic [N_W-1:0]  n_stg_o,
  output logic            tout_o
);
  logic wr_mode, wr_cmd, wr_l, wr_m, wr_n, wr_stat;

  assign wr_mode = wr_i && (addr_i == A_MODE);
  assign wr_cmd  = wr_i && (addr_i == A_CMD);
  assign wr_l    = wr_i && (addr_i == A_L);
  assign wr_m    = wr_i && (addr_i == A_M);
  assign wr_n    = wr_i && (addr_i == A_N);
  assign wr_stat = wr_i && (addr_i == A_STAT);

  assign cmd_en_o   = wr_cmd && wdata_i[CMD_EN];
  assign cmd_dis_o  = wr_cmd && wdata_i[CMD_DIS];
  assign cmd_rate_o = wr_cmd && wdata_i[CMD_RATE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_cnt_o <= '0;
      bias_cnt_o <= '0;
      vote_en_o  <= 1'b0;
      vote_rst_o <= 1'b1;
    end else if (wr_mode) begin
      lock_cnt_o <= wdata_i[LOCK_LSB +: VCNT_W];
      bias_cnt_o <= wdata_i[BIAS_LSB +: VCNT_W];
      vote_rst_o <= wdata_i[VRST_BIT];
      // arming needs the FSM reset already released and kept released
      vote_en_o  <= wdata_i[VEN_BIT] & ~wdata_i[VRST_BIT] & ~vote_rst_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_stg_o <= '0;
      m_stg_o <= '0;
      n_stg_o <= '0;
    end else if (!busy_i) begin
      if (wr_l) l_stg_o <= wdata_i[L_W-1:0];
      if (wr_m) m_stg_o <= wdata_i[M_W-1:0];
      if (wr_n) n_stg_o <= wdata_i[N_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              tout_o <= 1'b0;
    else if (tout_set_i)                      tout_o <= 1'b1;
    else if (wr_stat && wdata_i[ST_TOUT])     tout_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MODE: begin
        rdata_o[2:0]                = ctl_i;
        rdata_o[LOCK_LSB +: VCNT_W] = lock_cnt_o;
        rdata_o[BIAS_LSB +: VCNT_W] = bias_cnt_o;
        rdata_o[VEN_BIT]            = vote_en_o;
        rdata_o[VRST_BIT]           = vote_rst_o;
      end
      A_L:    rdata_o[L_W-1:0] = l_stg_o;
      A_M:    rdata_o[M_W-1:0] = m_stg_o;
      A_N:    rdata_o[N_W-1:0] = n_stg_o;
      A_STAT: begin
        rdata_o[ST_BUSY] = busy_i;
        rdata_o[ST_TOUT] = tout_o;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pll_seq_sw.sv
module pll_seq_sw
  import pll_seq_pkg::*;
#(
  parameter int L_W        = 10,
  parameter int M_W        = 19,
  parameter int N_W        = 19,
  parameter int GAP_US     = 10,
  parameter int LOCK_TRIES = 200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_en_i,
  input  logic           cmd_dis_i,
  input  logic           cmd_rate_i,
  input  logic           tick_i,
  input  logic           lock_i,
  input  logic           vote_en_i,
  input  logic [L_W-1:0] l_stg_i,
  input  logic [M_W-1:0] m_stg_i,
  input  logic [N_W-1:0] n_stg_i,
  output pll_ctl_t       ctl_o,
  output logic           busy_o,
  output logic           tout_set_o,
  output logic [L_W-1:0] l_o,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o
);
  localparam int CNT_MAX = (GAP_US > LOCK_TRIES) ? GAP_US : LOCK_TRIES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_US - 1);
  localparam logic [CNT_W-1:0] TRY_LAST = CNT_W'(LOCK_TRIES - 1);

  sw_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             running;

  assign running    = ctl_o.out_en & ctl_o.byp_rel & ctl_o.rst_rel;
  assign busy_o     = (state_q != SW_IDLE);
  assign tout_set_o = !vote_en_i && !cmd_dis_i && (state_q == SW_POLL) &&
                      tick_i && !lock_i && (cnt_q == TRY_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_IDLE;
      cnt_q   <= '0;
      ctl_o   <= '0;
      l_o     <= '0;
      m_o     <= '0;
      n_o     <= '0;
    end else if (vote_en_i || cmd_dis_i) begin
      state_q <= SW_IDLE;
      cnt_q   <= '0;
      ctl_o   <= '0;
    end else begin
      unique case (state_q)
        SW_IDLE: begin
          if (cmd_rate_i) begin
            l_o <= l_stg_i;
            m_o <= m_stg_i;
            n_o <= n_stg_i;
            if (running) begin
              ctl_o   <= '0;
              state_q <= SW_RESTART;
            end
          end else if (cmd_en_i && !running) begin
            ctl_o   <= '{rst_rel: 1'b0, byp_rel: 1'b1, out_en: 1'b0};
            cnt_q   <= '0;
            state_q <= SW_GAP;
          end
        end
        SW_RESTART: begin
          ctl_o   <= '{rst_rel: 1'b0, byp_rel: 1'b1, out_en: 1'b0};
          cnt_q   <= '0;
          state_q <= SW_GAP;
        end
        SW_GAP: if (tick_i) begin
          if (cnt_q == GAP_LAST) begin
            ctl_o.rst_rel <= 1'b1;
            cnt_q         <= '0;
            state_q       <= SW_POLL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SW_POLL: if (tick_i) begin
          if (lock_i) begin
            ctl_o.out_en <= 1'b1;
            state_q      <= SW_IDLE;
          end else if (cnt_q == TRY_LAST) begin
            state_q <= SW_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_seq_vote.sv
module pll_seq_vote
  import pll_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vote_en_i,
  input  logic              vote_rst_i,
  input  logic              vote_req_i,
  input  logic              tick_i,
  input  logic              lock_i,
  input  logic [VCNT_W-1:0] bias_cnt_i,
  input  logic [VCNT_W-1:0] lock_cnt_i,
  output pll_ctl_t          ctl_o,
  output logic              busy_o
);
  vt_state_e         state_q;
  logic [VCNT_W-1:0] cnt_q;

  assign busy_o = (state_q == VT_BIAS) || (state_q == VT_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= VT_IDLE;
      cnt_q   <= '0;
      ctl_o   <= '0;
    end else if (!vote_en_i || vote_rst_i || !vote_req_i) begin
      state_q <= VT_IDLE;
      cnt_q   <= '0;
      ctl_o   <= '0;
    end else begin
      unique case (state_q)
        VT_IDLE: begin
          ctl_o.byp_rel <= 1'b1;
          cnt_q         <= '0;
          state_q       <= VT_BIAS;
        end
        VT_BIAS: begin
          if (cnt_q == bias_cnt_i) begin
            ctl_o.rst_rel <= 1'b1;
            cnt_q         <= '0;
            state_q       <= VT_LOCK;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        VT_LOCK: begin
          if (cnt_q == lock_cnt_i && lock_i) begin
            ctl_o.out_en <= 1'b1;
            state_q      <= VT_ON;
          end else if (tick_i && cnt_q != lock_cnt_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        VT_ON: state_q <= VT_ON;
        default: state_q <= VT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int L_W        = 10,
  parameter int M_W        = 19,
  parameter int N_W        = 19,
  parameter int GAP_US     = 10,
  parameter int LOCK_TRIES = 200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_wr_i,
  input  logic [2:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic           tick_i,
  input  logic           lock_i,
  input  logic           vote_req_i,
  output logic           byp_rel_o,
  output logic           rst_rel_o,
  output logic           out_en_o,
  output logic [L_W-1:0] l_o,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic           busy_o,
  output logic           timeout_o
);
  logic              cmd_en, cmd_dis, cmd_rate;
  logic [VCNT_W-1:0] lock_cnt, bias_cnt;
  logic              vote_en, vote_rst;
  logic [L_W-1:0]    l_stg;
  logic [M_W-1:0]    m_stg;
  logic [N_W-1:0]    n_stg;
  pll_ctl_t          sw_ctl, vt_ctl, ctl;
  logic              sw_busy, vt_busy, tout_set;

  pll_seq_regs #(.L_W(L_W), .M_W(M_W), .N_W(N_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy_o),
    .ctl_i      (ctl),
    .tout_set_i (tout_set),
    .cmd_en_o   (cmd_en),
    .cmd_dis_o  (cmd_dis),
    .cmd_rate_o (cmd_rate),
    .lock_cnt_o (lock_cnt),
    .bias_cnt_o (bias_cnt),
    .vote_en_o  (vote_en),
    .vote_rst_o (vote_rst),
    .l_stg_o    (l_stg),
    .m_stg_o    (m_stg),
    .n_stg_o    (n_stg),
    .tout_o     (timeout_o)
  );

  pll_seq_sw #(
    .L_W(L_W), .M_W(M_W), .N_W(N_W), .GAP_US(GAP_US), .LOCK_TRIES(LOCK_TRIES)
  ) u_sw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_en_i   (cmd_en),
    .cmd_dis_i  (cmd_dis),
    .cmd_rate_i (cmd_rate),
    .tick_i     (tick_i),
    .lock_i     (lock_i),
    .vote_en_i  (vote_en),
    .l_stg_i    (l_stg),
    .m_stg_i    (m_stg),
    .n_stg_i    (n_stg),
    .ctl_o      (sw_ctl),
    .busy_o     (sw_busy),
    .tout_set_o (tout_set),
    .l_o        (l_o),
    .m_o        (m_o),
    .n_o        (n_o)
  );

  pll_seq_vote u_vote (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vote_en_i  (vote_en),
    .vote_rst_i (vote_rst),
    .vote_req_i (vote_req_i),
    .tick_i     (tick_i),
    .lock_i     (lock_i),
    .bias_cnt_i (bias_cnt),
    .lock_cnt_i (lock_cnt),
    .ctl_o      (vt_ctl),
    .busy_o     (vt_busy)
  );

  assign ctl       = vote_en ? vt_ctl : sw_ctl;
  assign byp_rel_o = ctl.byp_rel;
  assign rst_rel_o = ctl.rst_rel;
  assign out_en_o  = ctl.out_en;
  assign busy_o    = sw_busy | vt_busy;
endmodule

// File: rtl/pll_seq_ctrl_chk.sv
module pll_seq_ctrl_chk #(
  parameter int L_W = 10
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_wr_i,
  input logic [2:0]     reg_addr_i,
  input logic [31:0]    reg_wdata_i,
  input logic           vote_req_i,
  input logic           vote_en,
  input logic           byp_rel_o,
  input logic           rst_rel_o,
  input logic           out_en_o,
  input logic           busy_o,
  input logic           timeout_o,
  input logic [L_W-1:0] l_o
);
  // R2
  out_needs_reset_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> rst_rel_o);

  // R2
  reset_needs_bypass_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_rel_o |-> byp_rel_o);

  // R2
  bypass_before_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_rel_o) |-> $past(byp_rel_o));

  // R5
  disable_clears_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd1 && reg_wdata_i[1] && !vote_en)
    |=> (!byp_rel_o && !rst_rel_o && !out_en_o));

  // R4
  timeout_output_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !out_en_o);

  // R7
  busy_divider_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(l_o));

  // R10
  vote_drop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vote_en && !vote_req_i) |=> (!byp_rel_o && !rst_rel_o && !out_en_o));
endmodule

bind pll_seq_ctrl pll_seq_ctrl_chk #(.L_W(L_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .vote_req_i  (vote_req_i),
  .vote_en     (vote_en),
  .byp_rel_o   (byp_rel_o),
  .rst_rel_o   (rst_rel_o),
  .out_en_o    (out_en_o),
  .busy_o      (busy_o),
  .timeout_o   (timeout_o),
  .l_o         (l_o)
);

// File: tb/pll_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_seq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tick_i;
  logic        lock_i = 1'b0;
  logic        vote_req_i = 1'b0;
  logic        byp_rel_o, rst_rel_o, out_en_o, busy_o, timeout_o;
  logic [9:0]  l_o;
  logic [18:0] m_o, n_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  // timebase: free-running pulse every 4 cycles, or hand-driven
  logic tick_en = 1'b1, man_tick = 1'b0, auto_tick = 1'b0;
  int   tdiv = 0;
  always @(negedge clk_i) begin
    tdiv      <= (tdiv + 1) % 4;
    auto_tick <= (tdiv == 3);
  end
  assign tick_i = tick_en ? auto_tick : man_tick;

  pll_seq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .tick_i(tick_i),
    .lock_i(lock_i), .vote_req_i(vote_req_i), .byp_rel_o(byp_rel_o),
    .rst_rel_o(rst_rel_o), .out_en_o(out_en_o), .l_o(l_o), .m_o(m_o), .n_o(n_o),
    .busy_o(busy_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int sw_st, sw_cnt, v_st, v_cnt;          // sw: 0 idle 1 gap 2 poll 3 restart; v: 0 idle 1 bias 2 lock 3 on
  bit sw_b, sw_r, sw_o, v_b, v_r, v_o;
  int lock_c, bias_c, l_s, m_s, n_s, l_a, m_a, n_a;
  bit v_en, v_rst, tout;

  function automatic bit mdl_busy();
    return (sw_st != 0) || (v_st == 1) || (v_st == 2);
  endfunction
  function automatic logic [2:0] mdl_ctl();
    return v_en ? {v_r, v_b, v_o} : {sw_r, sw_b, sw_o};
  endfunction
  function automatic logic [31:0] mdl_read(input logic [2:0] a);
    case (a)
      3'd0: return (32'(v_rst) << 21) | (32'(v_en) << 20) | (32'(bias_c) << 14) |
                   (32'(lock_c) << 8) | 32'(mdl_ctl());
      3'd2: return 32'(l_s);
      3'd3: return 32'(m_s);
      3'd4: return 32'(n_s);
      3'd5: return (32'(tout) << 1) | 32'(mdl_busy());
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_st = 0; sw_cnt = 0; v_st = 0; v_cnt = 0;
      sw_b = 0; sw_r = 0; sw_o = 0; v_b = 0; v_r = 0; v_o = 0;
      lock_c = 0; bias_c = 0; l_s = 0; m_s = 0; n_s = 0; l_a = 0; m_a = 0; n_a = 0;
      v_en = 0; v_rst = 1; tout = 0;
    end else begin
      bit c_en, c_dis, c_rate, ob, tset, ven_old;
      c_en   = reg_wr_i && reg_addr_i == 3'd1 && reg_wdata_i[0];
      c_dis  = reg_wr_i && reg_addr_i == 3'd1 && reg_wdata_i[1];
      c_rate = reg_wr_i && reg_addr_i == 3'd1 && reg_wdata_i[2];
      ob = mdl_busy();
      ven_old = v_en;
      tset = 0;
      // software path
      if (ven_old || c_dis) begin
        sw_st = 0; sw_cnt = 0; sw_b = 0; sw_r = 0; sw_o = 0;
      end else if (sw_st == 0) begin
        if (c_rate) begin
          l_a = l_s; m_a = m_s; n_a = n_s;
          if (sw_b && sw_r && sw_o) begin sw_b = 0; sw_r = 0; sw_o = 0; sw_st = 3; end
        end else if (c_en && !(sw_b && sw_r && sw_o)) begin
          sw_b = 1; sw_r = 0; sw_o = 0; sw_cnt = 0; sw_st = 1;
        end
      end else if (sw_st == 3) begin
        sw_b = 1; sw_cnt = 0; sw_st = 1;
      end else if (sw_st == 1 && tick_i) begin
        if (sw_cnt == 9) begin sw_r = 1; sw_cnt = 0; sw_st = 2; end
        else sw_cnt++;
      end else if (sw_st == 2 && tick_i) begin
        if (lock_i) begin sw_o = 1; sw_st = 0; end
        else if (sw_cnt == 199) begin tset = 1; sw_st = 0; end
        else sw_cnt++;
      end
      // voting path
      if (!ven_old || v_rst || !vote_req_i) begin
        v_st = 0; v_cnt = 0; v_b = 0; v_r = 0; v_o = 0;
      end else if (v_st == 0) begin
        v_b = 1; v_cnt = 0; v_st = 1;
      end else if (v_st == 1) begin
        if (v_cnt == bias_c) begin v_r = 1; v_cnt = 0; v_st = 2; end
        else if (tick_i) v_cnt++;
      end else if (v_st == 2) begin
        if (v_cnt == lock_c && lock_i) begin v_o = 1; v_st = 3; end
        else if (tick_i && v_cnt != lock_c) v_cnt++;
      end
      // registers
      if (reg_wr_i && reg_addr_i == 3'd0) begin
        v_en   = reg_wdata_i[20] && !reg_wdata_i[21] && !v_rst;
        v_rst  = reg_wdata_i[21];
        lock_c = int'(reg_wdata_i[13:8]);
        bias_c = int'(reg_wdata_i[19:14]);
      end
      if (reg_wr_i && !ob) begin
        if (reg_addr_i == 3'd2) l_s = int'(reg_wdata_i[9:0]);
        if (reg_addr_i == 3'd3) m_s = int'(reg_wdata_i[18:0]);
        if (reg_addr_i == 3'd4) n_s = int'(reg_wdata_i[18:0]);
      end
      if (tset) tout = 1;
      else if (reg_wr_i && reg_addr_i == 3'd5 && reg_wdata_i[1]) tout = 0;
    end
  end

  // per-cycle comparison, after the edge settles
  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      chk("R2 controls", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, {29'd0, mdl_ctl()});
      chk("R7 busy", {31'd0, busy_o}, {31'd0, mdl_busy()});
      chk("R4 timeout", {31'd0, timeout_o}, {31'd0, tout});
      chk("R8 dividers", {3'd0, l_o, m_o}, {3'd0, 10'(l_a), 19'(m_a)});
      chk("R8 divider n", {13'd0, n_o}, {13'd0, 19'(n_a)});
      chk("R1 readback", reg_rdata_o, mdl_read(reg_addr_i));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_out(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (out_en_o) break;
      @(negedge clk_i);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  logic [31:0] rv;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 controls", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'd0);
    chk("R1 busy/timeout", {30'd0, busy_o, timeout_o}, 32'd0);
    rd(3'd0, rv); chk("R1 mode", rv, 32'h0020_0000);

    // R8 rate apply while stopped
    wr(3'd2, 32'd5); wr(3'd3, 32'd7); wr(3'd4, 32'd9);
    wr(3'd1, 32'h4);
    chk("R8 load l", 32'(l_o), 32'd5);
    chk("R8 load n", 32'(n_o), 32'd9);
    chk("R8 no sequence", {31'd0, busy_o}, 32'd0);

    // R2 enable sequence
    lock_i = 1'b1;
    wr(3'd1, 32'h1);
    chk("R2 bypass first", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'b010);
    chk("R7 busy set", {31'd0, busy_o}, 32'd1);
    wr(3'd2, 32'd99);
    rd(3'd2, rv); chk("R7 divider write dropped", rv, 32'd5);
    wait_out(400);
    chk("R2 running", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'b111);
    chk("R7 busy clear", {31'd0, busy_o}, 32'd0);

    // R3 enable while running
    wr(3'd1, 32'h1);
    chk("R3 enable ignored", {28'd0, busy_o, rst_rel_o, byp_rel_o, out_en_o}, 32'b0111);

    // R8 rate change while running
    wr(3'd2, 32'd12);
    wr(3'd1, 32'h5);
    chk("R8 restart clears", {28'd0, busy_o, rst_rel_o, byp_rel_o, out_en_o}, 32'b1000);
    chk("R8 new l", 32'(l_o), 32'd12);
    wait_out(400);
    chk("R8 re-enabled", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'b111);

    // R5 disable, and disable with enable in one write
    wr(3'd1, 32'h2);
    chk("R5 disable", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'd0);
    wr(3'd1, 32'h3);
    chk("R5 disable beats enable", {28'd0, busy_o, rst_rel_o, byp_rel_o, out_en_o}, 32'd0);

    // R4 lock timeout
    lock_i = 1'b0;
    wr(3'd1, 32'h1);
    repeat (900) @(negedge clk_i);
    chk("R4 timeout flag", {31'd0, timeout_o}, 32'd1);
    chk("R4 output off", {28'd0, busy_o, rst_rel_o, byp_rel_o, out_en_o}, 32'b0110);

    // R6 write-one-to-clear
    wr(3'd5, 32'h0);
    chk("R6 zero write keeps", {31'd0, timeout_o}, 32'd1);
    wr(3'd5, 32'h2);
    chk("R6 cleared", {31'd0, timeout_o}, 32'd0);

    // R3 enable from partial state restarts
    wr(3'd1, 32'h1);
    chk("R3 partial restart", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'b010);
    wr(3'd1, 32'h2);

    // R5 disable in the same cycle as the lock tick
    tick_en = 1'b0;
    wr(3'd1, 32'h1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i) man_tick = 1'b1;
      @(negedge clk_i) man_tick = 1'b0;
    end
    chk("R2 reset after gap", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'b110);
    @(negedge clk_i);
    man_tick = 1'b1; lock_i = 1'b1;
    reg_wr_i = 1'b1; reg_addr_i = 3'd1; reg_wdata_i = 32'h2;
    @(negedge clk_i);
    man_tick = 1'b0; reg_wr_i = 1'b0;
    chk("R5 disable beats lock", {28'd0, busy_o, rst_rel_o, byp_rel_o, out_en_o}, 32'd0);
    tick_en = 1'b1;

    // R9 vote arming rules
    wr(3'd0, 32'h0030_0000);
    rd(3'd0, rv); chk("R9 arm with reset held", rv, 32'h0020_0000);
    wr(3'd0, 32'h0010_0000);
    rd(3'd0, rv); chk("R9 arm same write as release", rv, 32'h0000_0000);
    wr(3'd0, 32'h0010_8300);
    rd(3'd0, rv); chk("R9 armed", rv, 32'h0010_8300);

    // R10 voting sequence
    @(negedge clk_i) vote_req_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 bypass first", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'b010);
    wait_out(200);
    chk("R10 on", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'b111);
    wr(3'd1, 32'h2);
    chk("R5 disable ignored in vote", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'b111);
    wr(3'd1, 32'h1);
    chk("R3 enable ignored in vote", {31'd0, busy_o}, 32'd0);
    @(negedge clk_i) vote_req_i = 1'b0;
    @(negedge clk_i);
    chk("R10 drop clears", {29'd0, rst_rel_o, byp_rel_o, out_en_o}, 32'd0);
    wr(3'd0, 32'h0030_0000);
    rd(3'd0, rv); chk("R9 reset disarms", rv, 32'h0020_0000);

    repeat (4) @(negedge clk_i);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end
endmodule